// File: doc/BRIEF.md
# On-Screen Display Command Decoder

This block sits behind a chip-select framed serial host port of a character overlay controller and receives the command bytes once they have been deserialized. It decodes two multi-byte commands. The horizontal setup command selects the character width of each of the two text lines, the dot-clock source and the horizontal start position. The display control command carries a test flag, an oscillator stop request, a display RAM erase request and a system reset.

The decoded fields drive the video timing logic directly. The block also gates a display-enable flag that comes from the rest of the controller. It owns an erase sequencer that writes the fill code to every display RAM address, one address per clock. The sequencer then waits for a programmable number of cycles so that the whole erase lasts as long as the RAM clear is specified to take. While it runs it raises a busy flag.

Top module: `osd_cmd_decoder`

## Requirements
- R1: A byte with `cs_n` low, `byte_valid` high and bits 7:4 equal to 1011 loads bits 3:2 into `hsize_code_l2` and bits 1:0 into `hsize_code_l1`, visible after the accepting clock edge, and arms a follow-on byte.
- R2: A byte with bit 7 = 0 that arrives while a follow-on byte is armed loads bit 6 into `dot_clk_xtal` (1 = crystal, 0 = LC) and bits 5:0 into `hstart_pos`, then disarms.
- R3: `hstart_delay` always equals twice `hstart_pos`, in oscillator periods.
- R4: `dot_per_l1` and `dot_per_l2` give the oscillator periods per dot for each line's size code: 00→1, 01→2, 10→3, 11→1.
- R5: A byte with bits 7:4 equal to 1100 and bit 0 = 0 loads bit 3 into `test_mode` and bit 1 into the oscillator stop request. Bit 2 = 1 requests an erase.
- R6: `osc_stop` is 1 one cycle after the stop request is set, `display_en` is 0 and `ext_sync_i` is 1. Otherwise it is 0.
- R7: An accepted erase raises `erase_busy` at the accepting edge. It then writes `FILL_CODE` (0x7F) to addresses 0 to RAM_DEPTH-1, in ascending order, one per cycle. After that it waits ERASE_PAD cycles, so `erase_busy` is high for RAM_DEPTH+ERASE_PAD cycles.
- R8: An erase request is ignored while `display_en` is 1 or while an erase is already running.
- R9: A display control byte with bit 0 = 1 clears all fields, drops `display_en` and aborts any erase at once. The block then ignores every byte while `cs_n` stays low and resumes after `cs_n` goes high.
- R10: While `rst` is high at a clock edge, all fields, `display_en`, `osc_stop` and the erase sequencer are zero.
- R11: The following leave every field unchanged: a byte with bit 7 = 1 and any other identification code, a bit-7 = 0 byte with no armed follow-on, and any byte while `cs_n` is high. An unrecognized first byte also disarms a pending follow-on.
- R12: `display_en` follows `display_on_i` one cycle later, except while a system reset holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| cs_n | input | 1 | Host chip-select, active low |
| byte_valid | input | 1 | A deserialized command byte is present |
| byte_data | input | 8 | Command byte |
| display_on_i | input | 1 | Display on request from the rest of the controller |
| ext_sync_i | input | 1 | External sync mode is selected |
| hsize_code_l1 | output | 2 | Line 1 character size code |
| hsize_code_l2 | output | 2 | Line 2 character size code |
| dot_per_l1 | output | 2 | Line 1 oscillator periods per dot |
| dot_per_l2 | output | 2 | Line 2 oscillator periods per dot |
| dot_clk_xtal | output | 1 | Dot clock source, 1 = crystal |
| hstart_pos | output | 6 | Horizontal start value |
| hstart_delay | output | 7 | Horizontal start delay in oscillator periods |
| test_mode | output | 1 | Test mode flag |
| osc_stop | output | 1 | Gated oscillator stop |
| display_en | output | 1 | Display enable |
| erase_busy | output | 1 | Erase sequence running |
| ram_we | output | 1 | Display RAM write enable |
| ram_addr | output | $clog2(RAM_DEPTH) | Display RAM address |
| ram_wdata | output | DATA_W | Display RAM write data |

## Verification
A wrong follow-on flag shows at `hstart_pos` and `dot_clk_xtal` right after the next bit-7 = 0 byte: a stray byte gets through, or a valid one is dropped. A fault in the erase counter shows within one cycle as a skipped or repeated `ram_addr`. A wrong pad count shows at the end of the sequence, as `erase_busy` falling early or late. A stuck reset hold keeps `display_en` low, and a hold that never takes effect lets bytes reach the fields, both within two cycles of `cs_n` changing.

// File: rtl/osd_cmd_pkg.sv
package osd_cmd_pkg;

  localparam logic [3:0] ID_HSET = 4'b1011;
  localparam logic [3:0] ID_DCTL = 4'b1100;

  typedef struct packed {
    logic [1:0] size_l2;
    logic [1:0] size_l1;
    logic       xtal;
    logic [5:0] hpos;
    logic       test;
    logic       osc_req;
  } osd_fields_t;

  function automatic logic [1:0] periods_per_dot(input logic [1:0] code);
    case (code)
      2'b01:   periods_per_dot = 2'd2;
      2'b10:   periods_per_dot = 2'd3;
      default: periods_per_dot = 2'd1;
    endcase
  endfunction

endpackage

// File: rtl/osd_cmd_parse.sv
module osd_cmd_parse
  import osd_cmd_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        cs_n,
  input  logic        byte_valid,
  input  logic [7:0]  byte_data,
  output osd_fields_t fields,
  output logic        erase_req,
  output logic        sysrst_now,
  output logic        hold
);

  logic       pending;
  logic       take;
  logic [3:0] id;

  assign id         = byte_data[7:4];
  assign take       = byte_valid && !cs_n && !hold;
  assign sysrst_now = take && id == ID_DCTL && byte_data[0];
  assign erase_req  = take && id == ID_DCTL && byte_data[2] && !byte_data[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      fields  <= '0;
      pending <= 1'b0;
      hold    <= 1'b0;
    end else if (hold) begin
      fields  <= '0;
      pending <= 1'b0;
      if (cs_n) hold <= 1'b0;
    end else if (cs_n) begin
      pending <= 1'b0;
    end else if (byte_valid) begin
      if (byte_data[7]) begin
        pending <= 1'b0;
        case (id)
          ID_HSET: begin
            fields.size_l2 <= byte_data[3:2];
            fields.size_l1 <= byte_data[1:0];
            pending        <= 1'b1;
          end
          ID_DCTL: begin
            if (byte_data[0]) begin
              fields <= '0;
              hold   <= 1'b1;
            end else begin
              fields.test    <= byte_data[3];
              fields.osc_req <= byte_data[1];
            end
          end
          default: ;
        endcase
      end else if (pending) begin
        fields.xtal <= byte_data[6];
        fields.hpos <= byte_data[5:0];
        pending     <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/osd_erase_seq.sv
module osd_erase_seq #(
  parameter int          RAM_DEPTH = 288,
  parameter int          ERASE_PAD = 62212,
  parameter int          DATA_W    = 8,
  parameter logic [DATA_W-1:0] FILL_CODE = 8'h7F,
  localparam int         ADDR_W    = $clog2(RAM_DEPTH),
  localparam int         PAD_W     = (ERASE_PAD > 1) ? $clog2(ERASE_PAD) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              abort,
  input  logic              start,
  output logic              busy,
  output logic              we,
  output logic [ADDR_W-1:0] addr,
  output logic [DATA_W-1:0] wdata
);

  typedef enum logic [1:0] {S_IDLE, S_WRITE, S_PAD} seq_state_t;

  seq_state_t       state;
  logic [PAD_W-1:0] pad_cnt;

  always_ff @(posedge clk) begin
    if (rst || abort) begin
      state   <= S_IDLE;
      addr    <= '0;
      pad_cnt <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          state <= S_WRITE;
          addr  <= '0;
        end
        S_WRITE: begin
          if (addr == ADDR_W'(RAM_DEPTH - 1)) begin
            addr    <= '0;
            pad_cnt <= '0;
            state   <= (ERASE_PAD == 0) ? S_IDLE : S_PAD;
          end else begin
            addr <= addr + 1'b1;
          end
        end
        S_PAD: begin
          if (pad_cnt == PAD_W'(ERASE_PAD - 1)) state <= S_IDLE;
          pad_cnt <= pad_cnt + 1'b1;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy  = state != S_IDLE;
  assign we    = state == S_WRITE;
  assign wdata = FILL_CODE;

endmodule

// File: rtl/osd_cmd_decoder.sv
module osd_cmd_decoder
  import osd_cmd_pkg::*;
#(
  parameter int          RAM_DEPTH = 288,
  parameter int          ERASE_PAD = 62212,
  parameter int          DATA_W    = 8,
  parameter logic [DATA_W-1:0] FILL_CODE = 8'h7F,
  localparam int         ADDR_W    = $clog2(RAM_DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              byte_valid,
  input  logic [7:0]        byte_data,
  input  logic              display_on_i,
  input  logic              ext_sync_i,
  output logic [1:0]        hsize_code_l1,
  output logic [1:0]        hsize_code_l2,
  output logic [1:0]        dot_per_l1,
  output logic [1:0]        dot_per_l2,
  output logic              dot_clk_xtal,
  output logic [5:0]        hstart_pos,
  output logic [6:0]        hstart_delay,
  output logic              test_mode,
  output logic              osc_stop,
  output logic              display_en,
  output logic              erase_busy,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [DATA_W-1:0] ram_wdata
);

  localparam int N_LINES = 2;

  osd_fields_t fields;
  logic        erase_req;
  logic        sysrst_now;
  logic        hold;
  logic        clear_all;
  logic [1:0]  size_code [N_LINES];
  logic [1:0]  dot_per   [N_LINES];

  osd_cmd_parse u_parse (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .byte_valid (byte_valid),
    .byte_data  (byte_data),
    .fields     (fields),
    .erase_req  (erase_req),
    .sysrst_now (sysrst_now),
    .hold       (hold)
  );

  assign clear_all = hold || sysrst_now;

  osd_erase_seq #(
    .RAM_DEPTH (RAM_DEPTH),
    .ERASE_PAD (ERASE_PAD),
    .DATA_W    (DATA_W),
    .FILL_CODE (FILL_CODE)
  ) u_erase (
    .clk   (clk),
    .rst   (rst),
    .abort (clear_all),
    .start (erase_req && !display_en),
    .busy  (erase_busy),
    .we    (ram_we),
    .addr  (ram_addr),
    .wdata (ram_wdata)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      display_en <= 1'b0;
      osc_stop   <= 1'b0;
    end else begin
      display_en <= display_on_i && !clear_all;
      osc_stop   <= fields.osc_req && !display_en && ext_sync_i && !clear_all;
    end
  end

  assign size_code[0] = fields.size_l1;
  assign size_code[1] = fields.size_l2;

  for (genvar g = 0; g < N_LINES; g++) begin : g_line
    assign dot_per[g] = periods_per_dot(size_code[g]);
  end

  assign hsize_code_l1 = fields.size_l1;
  assign hsize_code_l2 = fields.size_l2;
  assign dot_per_l1    = dot_per[0];
  assign dot_per_l2    = dot_per[1];
  assign dot_clk_xtal  = fields.xtal;
  assign hstart_pos    = fields.hpos;
  assign hstart_delay  = {fields.hpos, 1'b0};
  assign test_mode     = fields.test;

endmodule

// File: rtl/osd_cmd_checker.sv
module osd_cmd_checker #(
  parameter int ADDR_W = 9
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              byte_valid,
  input logic [7:0]        byte_data,
  input logic              ext_sync_i,
  input logic              display_en,
  input logic              osc_stop,
  input logic              erase_busy,
  input logic              ram_we,
  input logic [ADDR_W-1:0] ram_addr,
  input logic [5:0]        hstart_pos
);

  p_we_only_busy_r7: assert property (@(posedge clk) disable iff (rst)
    ram_we |-> erase_busy);

  p_addr_step_r7: assert property (@(posedge clk) disable iff (rst)
    (ram_we && $past(ram_we)) |-> ram_addr == ADDR_W'($past(ram_addr) + 1'b1));

  p_erase_needs_off_r8: assert property (@(posedge clk) disable iff (rst)
    $rose(erase_busy) |-> $past(!display_en));

  p_sysrst_clears_r9: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !cs_n && byte_valid && byte_data[7:4] == 4'b1100 && byte_data[0])
      |-> (hstart_pos == 6'd0 && !display_en && !erase_busy));

  p_osc_gate_r6: assert property (@(posedge clk) disable iff (rst)
    osc_stop |-> $past(!display_en && ext_sync_i));

  p_unknown_keeps_r11: assert property (@(posedge clk) disable iff (rst)
    $past(!rst && !cs_n && byte_valid && byte_data[7] &&
          byte_data[7:4] != 4'b1011 && byte_data[7:4] != 4'b1100)
      |-> $stable(hstart_pos));

endmodule

bind osd_cmd_decoder osd_cmd_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .cs_n       (cs_n),
  .byte_valid (byte_valid),
  .byte_data  (byte_data),
  .ext_sync_i (ext_sync_i),
  .display_en (display_en),
  .osc_stop   (osc_stop),
  .erase_busy (erase_busy),
  .ram_we     (ram_we),
  .ram_addr   (ram_addr),
  .hstart_pos (hstart_pos)
);

// File: tb/osd_cmd_decoder_tb.sv
`timescale 1ns/1ps
module osd_cmd_decoder_tb;

  localparam int DEPTH  = 16;
  localparam int PAD    = 5;
  localparam int AW     = $clog2(DEPTH);
  localparam int NVEC   = 12;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          cs_n = 1'b0;
  logic          byte_valid = 1'b0;
  logic [7:0]    byte_data = 8'h00;
  logic          display_on_i = 1'b0;
  logic          ext_sync_i = 1'b0;
  logic [1:0]    hsize_code_l1, hsize_code_l2, dot_per_l1, dot_per_l2;
  logic          dot_clk_xtal, test_mode, osc_stop, display_en, erase_busy, ram_we;
  logic [5:0]    hstart_pos;
  logic [6:0]    hstart_delay;
  logic [AW-1:0] ram_addr;
  logic [7:0]    ram_wdata;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  osd_cmd_decoder #(.RAM_DEPTH(DEPTH), .ERASE_PAD(PAD)) u_dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .byte_valid(byte_valid), .byte_data(byte_data),
    .display_on_i(display_on_i), .ext_sync_i(ext_sync_i),
    .hsize_code_l1(hsize_code_l1), .hsize_code_l2(hsize_code_l2),
    .dot_per_l1(dot_per_l1), .dot_per_l2(dot_per_l2), .dot_clk_xtal(dot_clk_xtal),
    .hstart_pos(hstart_pos), .hstart_delay(hstart_delay), .test_mode(test_mode),
    .osc_stop(osc_stop), .display_en(display_en), .erase_busy(erase_busy),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata)
  );

  // {byte, expected hpos, expected xtal, expected line2 code, expected line1 code}
  localparam logic [18:0] VEC [NVEC] = '{
    {8'hB6, 6'd0,  1'b0, 2'b01, 2'b10},
    {8'h55, 6'd21, 1'b1, 2'b01, 2'b10},
    {8'h15, 6'd21, 1'b1, 2'b01, 2'b10},
    {8'hB9, 6'd21, 1'b1, 2'b10, 2'b01},
    {8'h3F, 6'd63, 1'b0, 2'b10, 2'b01},
    {8'hE3, 6'd63, 1'b0, 2'b10, 2'b01},
    {8'h00, 6'd63, 1'b0, 2'b10, 2'b01},
    {8'hBF, 6'd63, 1'b0, 2'b11, 2'b11},
    {8'hA0, 6'd63, 1'b0, 2'b11, 2'b11},
    {8'h40, 6'd63, 1'b0, 2'b11, 2'b11},
    {8'hB0, 6'd63, 1'b0, 2'b00, 2'b00},
    {8'h40, 6'd0,  1'b1, 2'b00, 2'b00}
  };

  function automatic int per_dot(input logic [1:0] code);
    case (code)
      2'b01:   return 2;
      2'b10:   return 3;
      default: return 1;
    endcase
  endfunction

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic send(input logic [7:0] b);
    @(negedge clk);
    byte_valid = 1'b1;
    byte_data  = b;
    @(negedge clk);
    byte_valid = 1'b0;
  endtask

  task automatic wait_cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  initial begin : watchdog
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) disable watchdog;
    end
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait_cycles(3);
    rst = 1'b0;
    @(negedge clk);
    // R10 reset state
    check("R10 hstart", hstart_pos, 0);
    check("R10 sizes", {hsize_code_l2, hsize_code_l1}, 0);
    check("R10 busy", erase_busy, 0);
    check("R10 display_en", display_en, 0);

    // R1 R2 R3 R4 R11 vector table
    for (int v = 0; v < NVEC; v++) begin
      send(VEC[v][18:11]);
      check("R2 hstart", hstart_pos, VEC[v][10:5]);
      check("R3 delay", hstart_delay, 2 * VEC[v][10:5]);
      check("R2 xtal", dot_clk_xtal, VEC[v][4]);
      check("R1 line2", hsize_code_l2, VEC[v][3:2]);
      check("R1 line1", hsize_code_l1, VEC[v][1:0]);
      check("R4 per dot l2", dot_per_l2, per_dot(VEC[v][3:2]));
      check("R4 per dot l1", dot_per_l1, per_dot(VEC[v][1:0]));
    end

    // R11 bytes ignored while cs_n high
    cs_n = 1'b1;
    send(8'hBF);
    check("R11 cs high size", {hsize_code_l2, hsize_code_l1}, 0);
    cs_n = 1'b0;

    // R7 erase sequence, R8 second request during busy is ignored
    send(8'hC4);
    for (int k = 0; k < DEPTH + PAD; k++) begin
      check("R7 busy", erase_busy, 1);
      if (k < DEPTH) begin
        check("R7 we", ram_we, 1);
        check("R7 addr", ram_addr, k);
        check("R7 data", ram_wdata, 8'h7F);
      end else begin
        check("R7 pad we", ram_we, 0);
      end
      if (k == DEPTH + 2) begin
        byte_valid = 1'b1;
        byte_data  = 8'hC4;
      end
      @(negedge clk);
      byte_valid = 1'b0;
    end
    check("R7 busy end", erase_busy, 0);
    @(negedge clk);
    check("R8 busy request ignored", erase_busy, 0);

    // R12 display enable, R8 erase refused while display on
    display_on_i = 1'b1;
    @(negedge clk);
    check("R12 display_en", display_en, 1);
    send(8'hC4);
    check("R8 display on", erase_busy, 0);
    @(negedge clk);
    check("R8 display on we", ram_we, 0);

    // R5 R6 oscillator stop gating
    ext_sync_i = 1'b1;
    send(8'hC2);
    @(negedge clk);
    check("R6 display on", osc_stop, 0);
    check("R5 test clear", test_mode, 0);
    display_on_i = 1'b0;
    wait_cycles(2);
    check("R6 stop active", osc_stop, 1);
    ext_sync_i = 1'b0;
    wait_cycles(2);
    check("R6 no ext sync", osc_stop, 0);
    send(8'hC8);
    check("R5 test set", test_mode, 1);
    send(8'hC0);
    check("R5 test cleared", test_mode, 0);

    // R9 system reset aborts erase and holds
    send(8'hB5);
    send(8'h2A);
    check("R2 hstart 42", hstart_pos, 42);
    send(8'hC4);
    wait_cycles(3);
    check("R7 running", erase_busy, 1);
    display_on_i = 1'b1;
    send(8'hC1);
    check("R9 hstart cleared", hstart_pos, 0);
    check("R9 erase aborted", erase_busy, 0);
    check("R9 display off", display_en, 0);
    send(8'hB5);
    check("R9 hold ignores", hsize_code_l1, 0);
    wait_cycles(2);
    check("R9 display held off", display_en, 0);
    cs_n = 1'b1;
    wait_cycles(2);
    check("R12 display after release", display_en, 1);
    cs_n = 1'b0;
    send(8'hB5);
    check("R9 released", hsize_code_l1, 1);

    // R10 synchronous reset
    send(8'h55);
    rst = 1'b1;
    @(negedge clk);
    check("R10 hstart", hstart_pos, 0);
    check("R10 size", hsize_code_l1, 0);
    check("R10 display_en", display_en, 0);
    rst = 1'b0;
    send(8'h55);
    check("R11 no pending after reset", hstart_pos, 0);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule